// File: doc/BRIEF.md
# Programmable SPI Serial Clock Generator

This block derives the serial clock of an SPI engine from the system clock, together with one-cycle enables that mark the rising and falling edges of that clock. The shift and sample logic of the engine uses those enables, so it never has to detect edges of a divided clock.

A clock configuration word carries three 6-bit counts: a divider value `n`, a count at which the clock goes high, and a count at which it goes low. A phase counter runs from 0 to `n` and wraps, so one serial period is `n+1` system cycles. The two compare points are independent, which gives any duty cycle and any phase inside the period. A common setting is low count `n` and high count `(n+1)/2-1`, which gives close to 50% duty. Between `n=1` (divide by 2) and `n=63` (divide by 64) the clock runs while `active_i` is high. While it is low, the counter is parked at 0 and the clock idles low.

Top module: `sclk_gen`

## Requirements
- R1: While `rst_n` is low, `sclk_o`, `rise_o` and `fall_o` are 0. They stay 0 after reset until `active_i` has been sampled high.
- R2: The divider value is taken from `cfg_i[17:12]`, the high count from `cfg_i[11:6]` and the low count from `cfg_i[5:0]`. Every other bit of `cfg_i`, including bit 31 (clock source select, decoded elsewhere), has no effect on any output.
- R3: While `active_i` stays high, the phase counter steps 0,1,…,n,0,… on every system clock edge. Every serial clock period is therefore n+1 system cycles long.
- R4: The counter value at a clock edge decides `sclk_o` after that edge. A value equal to the high count drives it to 1, and a value equal to the low count drives it to 0. When the two counts are equal, low wins and the clock stays low.
- R5: If the high count is greater than n, `sclk_o` never goes high. If the high count is at most n and the low count is greater than n, `sclk_o` goes high once and then stays high.
- R6: `rise_o` is 1 for exactly the cycles in which `sclk_o` has just changed from 0 to 1. `fall_o` is 1 for exactly the cycles in which `sclk_o` has just changed from 1 to 0 while the block is active. The two are never 1 together.
- R7: One edge after `active_i` is sampled low, `sclk_o`, `rise_o` and `fall_o` are all 0. Dropping the clock this way produces no `fall_o` pulse.
- R8: The counter is 0 in the first active cycle, so the first period has full length. With high count h (h ≤ n), `sclk_o` first goes high h+1 edges after `active_i` is sampled high.
- R9: A divider field of 0 is treated as 1. The fastest serial clock is the system clock divided by 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| active_i | input | 1 | High while a transfer runs; low parks the clock |
| cfg_i | input | 32 | Clock configuration word (divider, high count, low count) |
| sclk_o | output | 1 | Serial clock, idles low |
| rise_o | output | 1 | One-cycle pulse with each rising edge of `sclk_o` |
| fall_o | output | 1 | One-cycle pulse with each falling edge of `sclk_o` |

## Verification
A phase counter that wraps at the wrong value shows up at the ports as a period of the wrong length. This is visible within one serial period, at the second rising edge at the latest. A compare fault, or a wrong priority between the two compare points, appears as a level that is wrong inside the first period. A counter that is not parked or cleared at start shifts the first rising edge away from edge h+1. Pulse faults appear in the same cycle as the level change they should mark. The sweep therefore compares every output on every cycle of several periods.

// File: rtl/sclk_gen_pkg.sv
package sclk_gen_pkg;
  localparam int unsigned FIELD_W = 6;
  localparam int unsigned LO_LSB  = 0;
  localparam int unsigned HI_LSB  = LO_LSB + FIELD_W;
  localparam int unsigned DIV_LSB = HI_LSB + FIELD_W;

  typedef struct packed {
    logic [FIELD_W-1:0] div;
    logic [FIELD_W-1:0] hi;
    logic [FIELD_W-1:0] lo;
  } clk_fields_t;
endpackage

// File: rtl/sclk_cfg_decode.sv
module sclk_cfg_decode
  import sclk_gen_pkg::*;
#(
  parameter int unsigned CFG_W = 32
) (
  input  logic [CFG_W-1:0] cfg_i,
  output clk_fields_t      fields_o
);
  localparam logic [FIELD_W-1:0] MIN_DIV = FIELD_W'(1);

  logic [FIELD_W-1:0] raw_div;

  always_comb begin
    raw_div      = cfg_i[DIV_LSB +: FIELD_W];
    fields_o.div = (raw_div == '0) ? MIN_DIV : raw_div;
    fields_o.hi  = cfg_i[HI_LSB +: FIELD_W];
    fields_o.lo  = cfg_i[LO_LSB +: FIELD_W];
  end

  // R9
  always_comb begin
    min_div_chk: assert (fields_o.div != '0);
  end
endmodule

// File: rtl/sclk_phase_counter.sv
module sclk_phase_counter #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [CNT_W-1:0] div_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (!rst_n || !run_i) begin
      cnt_o <= '0;
    end else if (cnt_o >= div_i) begin
      cnt_o <= '0;
    end else begin
      cnt_o <= cnt_o + CNT_W'(1);
    end
  end

  // R8
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_i) |-> (cnt_o == '0));

  // R3
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && $past(run_i) && $stable(div_i) && $past(cnt_o) < div_i)
      |-> (cnt_o == $past(cnt_o) + CNT_W'(1)));
endmodule

// File: rtl/sclk_edge_gen.sv
module sclk_edge_gen #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] hi_i,
  input  logic [CNT_W-1:0] lo_i,
  output logic             sclk_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic lvl_nxt;

  always_comb begin
    lvl_nxt = sclk_o;
    if (cnt_i == hi_i) lvl_nxt = 1'b1;
    if (cnt_i == lo_i) lvl_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i) begin
      sclk_o <= 1'b0;
      rise_o <= 1'b0;
      fall_o <= 1'b0;
    end else begin
      sclk_o <= lvl_nxt;
      rise_o <= lvl_nxt & ~sclk_o;
      fall_o <= ~lvl_nxt & sclk_o;
    end
  end

  // R6
  edges_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_o && fall_o));

  // R6
  rise_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |-> (sclk_o && !$past(sclk_o)));

  // R7
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (!sclk_o && !rise_o && !fall_o));
endmodule

// File: rtl/sclk_gen.sv
module sclk_gen
  import sclk_gen_pkg::*;
#(
  parameter int unsigned CFG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             sclk_o,
  output logic             rise_o,
  output logic             fall_o
);
  clk_fields_t        fields;
  logic [FIELD_W-1:0] phase;

  sclk_cfg_decode #(.CFG_W(CFG_W)) u_decode (
    .cfg_i    (cfg_i),
    .fields_o (fields)
  );

  sclk_phase_counter #(.CNT_W(FIELD_W)) u_counter (
    .clk   (clk),
    .rst_n (rst_n),
    .run_i (active_i),
    .div_i (fields.div),
    .cnt_o (phase)
  );

  sclk_edge_gen #(.CNT_W(FIELD_W)) u_edges (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (active_i),
    .cnt_i  (phase),
    .hi_i   (fields.hi),
    .lo_i   (fields.lo),
    .sclk_o (sclk_o),
    .rise_o (rise_o),
    .fall_o (fall_o)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!sclk_o && !rise_o && !fall_o));
endmodule

// File: tb/sclk_gen_bench.sv
module sclk_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        active_i = 1'b0;
  logic [31:0] cfg_i = '0;
  logic        sclk_o, rise_o, fall_o;
  int          n_checks = 0;
  int          n_fails = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  sclk_gen u_sclk_gen (
    .clk(clk), .rst_n(rst_n), .active_i(active_i), .cfg_i(cfg_i),
    .sclk_o(sclk_o), .rise_o(rise_o), .fall_o(fall_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: got %0d expected %0d (cfg=%h t=%0t)", req, act, exp, cfg_i, $time);
    end
  endtask

  // Expected level after active edge e (e>=1), derived from R3-R5, R8, R9
  function automatic int exp_lvl(int e, int n, int hi, int lo);
    int c;
    if (e <= 0) return 0;
    c = (e - 1) % (n + 1);
    if (hi > n) return 0;
    if ((e - 1) < hi) return 0;
    if (lo > n) return 1;
    if (hi < lo) return (c >= hi && c < lo) ? 1 : 0;
    if (hi > lo) return (c >= hi || c < lo) ? 1 : 0;
    return 0;
  endfunction

  task automatic run_cfg(input int dfield, input int hi, input int lo, input int junk, input int edges);
    int n;
    n = (dfield == 0) ? 1 : dfield;
    @(negedge clk);
    cfg_i = {junk[13:0], dfield[5:0], hi[5:0], lo[5:0]};
    if (junk[0]) cfg_i[31] = 1'b1;
    @(negedge clk);
    check("R7 idle level", sclk_o, 0);
    active_i = 1'b1;
    for (int e = 1; e <= edges; e++) begin
      @(negedge clk);
      check("R2/R3/R4/R5/R8/R9 level", sclk_o, exp_lvl(e, n, hi, lo));
      check("R6 rise pulse", rise_o,
            (exp_lvl(e, n, hi, lo) == 1 && exp_lvl(e - 1, n, hi, lo) == 0) ? 1 : 0);
      check("R6 fall pulse", fall_o,
            (exp_lvl(e, n, hi, lo) == 0 && exp_lvl(e - 1, n, hi, lo) == 1) ? 1 : 0);
    end
    active_i = 1'b0;
    @(negedge clk);
    check("R7 stop level", sclk_o, 0);
    check("R7 stop no fall", fall_o, 0);
    check("R7 stop no rise", rise_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset sclk", sclk_o, 0);
    check("R1 reset rise", rise_o, 0);
    check("R1 reset fall", fall_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 post-reset quiet", sclk_o | rise_o | fall_o, 0);
    for (int d = 0; d < 8; d++)
      for (int h = 0; h < 9; h++)
        for (int l = 0; l < 9; l++)
          run_cfg(d, h, l, (d * 81 + h * 9 + l) * 2731, 3 * ((d == 0 ? 1 : d) + 1) + 1);
    // R2: unused bits all set, standard settings at slowest and fastest rates
    run_cfg(63, 31, 63, 16383, 200);
    run_cfg(1, 0, 1, 16383, 10);
    run_cfg(6, 2, 6, 0, 30);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule